// File: doc/BRIEF.md
# Single-Transfer Address Generator

This block forms the memory address for one DSP load or store that may reach anywhere in the memory space, in either word (16-bit) or longword (32-bit) size. A request names one of four base pointer registers and one of four pointer update modes. The block captures the request, computes the address to present on the shared bus, and computes the new pointer value that goes back to the register file.

The four update modes are: leave the pointer alone, step it forward by the access size after the access, add the index register to it after the access, or step it back by the access size before the access. In that last mode the stepped-back value is both the address issued and the value written back. The bus is shared with other traffic, so the result can be stalled. The result holds while the stall lasts. The pointer write-back fires only in the cycle where the access is taken, so a pointer is never updated twice. Modulo wrapping is not offered on this path. Address arithmetic simply wraps at the address width.

Top module: `agen_single_xfer`

## Requirements
- R1: `reqBaseSel` picks the base pointer: 0 selects `ptrR2`, 1 `ptrR3`, 2 `ptrR4`, 3 `ptrR5`. `wbSel` returns the same code with the result.
- R2: A request is taken at a rising edge where `reqValid` and `reqReady` are both high. Its result appears on `memValid`, `memAddr`, `memLong`, `memMisalign` and `wbSel` from the following cycle.
- R3: Mode 0 (keep): `memAddr` equals the base, and `wbEn` stays low for the whole access.
- R4: Mode 1 (post-increment): `memAddr` equals the base, and `wbData` equals the base plus 2 for a word or plus 4 for a longword.
- R5: Mode 2 (post-index): `memAddr` equals the base, and `wbData` equals the base plus `idxR8`.
- R6: Mode 3 (pre-decrement): `memAddr` and `wbData` both equal the base minus 2 for a word or minus 4 for a longword.
- R7: `memLong` repeats `reqLong` of the taken request (1 = 32-bit, 0 = 16-bit).
- R8: While `memValid` and `memStall` are high, the outputs hold, `reqReady` is low and `wbEn` is low. `wbEn` is high for exactly one cycle per updating access: the cycle where `memValid` is high and `memStall` is low.
- R9: `memMisalign` is high when a longword address has bit 1 or bit 0 set, or when a word address has bit 0 set.
- R10: After reset, `memValid` and `wbEn` are low and `reqReady` is high.
- R11: Address sums and differences wrap modulo 2^ADDR_W. For example, pre-decrementing a word from 0 gives all ones except bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqBaseSel | input | 2 | Base pointer code |
| reqMode | input | 2 | Update mode: 0 keep, 1 post-inc, 2 post-index, 3 pre-dec |
| reqLong | input | 1 | 1 = longword, 0 = word |
| ptrR2 | input | ADDR_W | Pointer register value, code 0 |
| ptrR3 | input | ADDR_W | Pointer register value, code 1 |
| ptrR4 | input | ADDR_W | Pointer register value, code 2 |
| ptrR5 | input | ADDR_W | Pointer register value, code 3 |
| idxR8 | input | ADDR_W | Index register value |
| memStall | input | 1 | Bus not taking the access this cycle |
| memValid | output | 1 | Access presented on the bus |
| memAddr | output | ADDR_W | Access address |
| memLong | output | 1 | Access size, 1 = 32-bit |
| memMisalign | output | 1 | Address not aligned to the access size |
| wbEn | output | 1 | Pointer write-back strobe |
| wbSel | output | 2 | Pointer code to write back |
| wbData | output | ADDR_W | New pointer value |

## Verification
Address, size, misalignment flag and pointer code appear one cycle after the edge that takes the request. `wbEn` and `wbData` are due in the first cycle of that access without a stall, which may come many cycles later. The driver pushes the expected result at the accepting edge. The monitor samples on the falling edge and pops an item only in a cycle where `memValid` is high and `memStall` is low, so each expectation is matched against the exact cycle the bus takes it. In every stalled cycle the monitor instead checks that `wbEn` and `reqReady` are low and that the address has not moved.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP    = 2'b00,
    MODE_POSTINC = 2'b01,
    MODE_POSTIDX = 2'b10,
    MODE_PREDEC  = 2'b11
  } updMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // capture a new request this edge
    logic commit;    // the bus takes the current access this cycle
  } agenStrobe_t;

endpackage

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import agen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memStall,
  output logic        reqReady,
  output logic        memValid,
  output agenStrobe_t strobe
);

  logic validQ;
  logic busyHold;

  assign busyHold = validQ && memStall;
  assign reqReady = !busyHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (reqValid && reqReady) begin
      validQ <= 1'b1;
    end else if (!busyHold) begin
      validQ <= 1'b0;
    end
  end

  assign memValid       = validQ;
  assign strobe.loadReq = reqValid && reqReady;
  assign strobe.commit  = validQ && !memStall;

  AST_STALL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memStall) |-> !reqReady); // R8
  AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memStall) |=> memValid); // R8
  AST_IDLE_AFTER_NOREQ: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && !(memValid && memStall)) |=> !memValid); // R2

endmodule

// File: rtl/agen_datapath.sv
module agen_datapath
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_PTR  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  agenStrobe_t              strobe,
  input  logic [$clog2(N_PTR)-1:0] reqBaseSel,
  input  logic [1:0]               reqMode,
  input  logic                     reqLong,
  input  logic [ADDR_W-1:0]        ptrFile [N_PTR],
  input  logic [ADDR_W-1:0]        idxVal,
  output logic [ADDR_W-1:0]        memAddr,
  output logic                     memLong,
  output logic                     memMisalign,
  output logic                     wbEn,
  output logic [$clog2(N_PTR)-1:0] wbSel,
  output logic [ADDR_W-1:0]        wbData
);

  localparam int SEL_W = $clog2(N_PTR);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_LONG = ADDR_W'(4);

  updMode_e          modeIn;
  logic [ADDR_W-1:0] baseVal;
  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] incVal;
  logic [ADDR_W-1:0] decVal;
  logic [ADDR_W-1:0] idxSum;
  logic [ADDR_W-1:0] addrNext;
  logic [ADDR_W-1:0] wbNext;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] wbDataQ;
  logic [SEL_W-1:0]  selQ;
  logic              longQ;
  updMode_e          modeQ;

  assign modeIn  = updMode_e'(reqMode);
  assign baseVal = ptrFile[reqBaseSel];
  assign stepVal = reqLong ? STEP_LONG : STEP_WORD;
  assign incVal  = baseVal + stepVal;
  assign decVal  = baseVal - stepVal;
  assign idxSum  = baseVal + idxVal;

  always_comb begin
    addrNext = baseVal;
    wbNext   = baseVal;
    unique case (modeIn)
      MODE_KEEP:    wbNext = baseVal;
      MODE_POSTINC: wbNext = incVal;
      MODE_POSTIDX: wbNext = idxSum;
      MODE_PREDEC: begin
        addrNext = decVal;
        wbNext   = decVal;
      end
      default:      wbNext = baseVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wbDataQ <= '0;
      selQ    <= '0;
      longQ   <= 1'b0;
      modeQ   <= MODE_KEEP;
    end else if (strobe.loadReq) begin
      addrQ   <= addrNext;
      wbDataQ <= wbNext;
      selQ    <= reqBaseSel;
      longQ   <= reqLong;
      modeQ   <= modeIn;
    end
  end

  assign memAddr     = addrQ;
  assign memLong     = longQ;
  assign memMisalign = longQ ? (addrQ[1:0] != 2'b00) : addrQ[0];
  assign wbEn        = strobe.commit && (modeQ != MODE_KEEP);
  assign wbSel       = selQ;
  assign wbData      = wbDataQ;

  AST_KEEP_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_KEEP) |-> !wbEn); // R3
  AST_POSTINC_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn && modeQ == MODE_POSTINC) |-> ((wbData - memAddr) == (memLong ? STEP_LONG : STEP_WORD))); // R4
  AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn && modeQ == MODE_PREDEC) |-> (wbData == memAddr)); // R6

endmodule

// File: rtl/agen_single_xfer.sv
module agen_single_xfer
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqBaseSel,
  input  logic [1:0]        reqMode,
  input  logic              reqLong,
  input  logic [ADDR_W-1:0] ptrR2,
  input  logic [ADDR_W-1:0] ptrR3,
  input  logic [ADDR_W-1:0] ptrR4,
  input  logic [ADDR_W-1:0] ptrR5,
  input  logic [ADDR_W-1:0] idxR8,
  input  logic              memStall,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memLong,
  output logic              memMisalign,
  output logic              wbEn,
  output logic [1:0]        wbSel,
  output logic [ADDR_W-1:0] wbData
);

  localparam int N_PTR = 4;

  agenStrobe_t       strobe;
  logic [ADDR_W-1:0] ptrFile [N_PTR];

  assign ptrFile[0] = ptrR2;
  assign ptrFile[1] = ptrR3;
  assign ptrFile[2] = ptrR4;
  assign ptrFile[3] = ptrR5;

  agen_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .memStall (memStall),
    .reqReady (reqReady),
    .memValid (memValid),
    .strobe   (strobe)
  );

  agen_datapath #(
    .ADDR_W (ADDR_W),
    .N_PTR  (N_PTR)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqBaseSel  (reqBaseSel),
    .reqMode     (reqMode),
    .reqLong     (reqLong),
    .ptrFile     (ptrFile),
    .idxVal      (idxR8),
    .memAddr     (memAddr),
    .memLong     (memLong),
    .memMisalign (memMisalign),
    .wbEn        (wbEn),
    .wbSel       (wbSel),
    .wbData      (wbData)
  );

  AST_WB_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (memValid && !memStall)); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memStall) |=> ($stable(memAddr) && $stable(wbData) && $stable(wbSel))); // R8

endmodule

// File: tb/tb_agen_single_xfer.sv
module tb_agen_single_xfer;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [1:0]        reqBaseSel = '0;
  logic [1:0]        reqMode = '0;
  logic              reqLong = 1'b0;
  logic [ADDR_W-1:0] ptrR2 = '0, ptrR3 = '0, ptrR4 = '0, ptrR5 = '0, idxR8 = '0;
  logic              memStall = 1'b0;
  logic              memValid;
  logic [ADDR_W-1:0] memAddr;
  logic              memLong;
  logic              memMisalign;
  logic              wbEn;
  logic [1:0]        wbSel;
  logic [ADDR_W-1:0] wbData;

  always #4 clk = ~clk;  // 125 MHz

  agen_single_xfer #(.ADDR_W(ADDR_W)) dut (.*);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              lng;
    logic              mis;
    logic              wb;
    logic [1:0]        sel;
    logic [ADDR_W-1:0] data;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  logic [ADDR_W-1:0] lastStallAddr;
  logic              prevStalled = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected result computed from the requirements (R3..R6, R9, R11)
  function automatic expItem_t model(input logic [1:0] sel, input logic [1:0] mode,
                                     input logic lng, input logic [ADDR_W-1:0] base,
                                     input logic [ADDR_W-1:0] idx);
    expItem_t e;
    logic [ADDR_W-1:0] step;
    step = lng ? 32'd4 : 32'd2;
    e.sel = sel; e.lng = lng;
    e.addr = base; e.data = base; e.wb = 1'b1;
    case (mode)
      2'd0: e.wb = 1'b0;
      2'd1: e.data = base + step;
      2'd2: e.data = base + idx;
      default: begin e.addr = base - step; e.data = base - step; end
    endcase
    e.mis = lng ? (e.addr[1:0] != 2'b00) : e.addr[0];
    return e;
  endfunction

  // driver: present a request, wait for acceptance, push the expectation
  task automatic issue(input logic [1:0] sel, input logic [1:0] mode, input logic lng);
    logic [ADDR_W-1:0] base;
    reqBaseSel = sel; reqMode = mode; reqLong = lng; reqValid = 1'b1;
    case (sel)
      2'd0: base = ptrR2;
      2'd1: base = ptrR3;
      2'd2: base = ptrR4;
      default: base = ptrR5;
    endcase
    forever begin
      @(negedge clk);
      if (reqReady) break;
    end
    @(posedge clk);
    expQ.push_back(model(sel, mode, lng, base, idxR8));
    #1 reqValid = 1'b0;
  endtask

  // monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && memValid && memStall) begin
        check(!wbEn, "R8", "wbEn during stall", {31'd0, wbEn}, '0);
        check(!reqReady, "R8", "reqReady during stall", {31'd0, reqReady}, '0);
        if (prevStalled)
          check(memAddr == lastStallAddr, "R8", "memAddr held", memAddr, lastStallAddr);
        lastStallAddr = memAddr;
        prevStalled = 1'b1;
      end else begin
        prevStalled = 1'b0;
      end
      if (rstN && memValid && !memStall) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2", "unexpected access", memAddr, '0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(memAddr == e.addr, "R3/R4/R5/R6/R11", "memAddr", memAddr, e.addr);
          check(memLong == e.lng, "R7", "memLong", {31'd0, memLong}, {31'd0, e.lng});
          check(memMisalign == e.mis, "R9", "memMisalign", {31'd0, memMisalign}, {31'd0, e.mis});
          check(wbSel == e.sel, "R1", "wbSel", {30'd0, wbSel}, {30'd0, e.sel});
          check(wbEn == e.wb, "R3/R8", "wbEn", {31'd0, wbEn}, {31'd0, e.wb});
          if (e.wb)
            check(wbData == e.data, "R4/R5/R6/R11", "wbData", wbData, e.data);
        end
      end
      if (rstN && !memValid)
        check(!wbEn, "R8", "wbEn while idle", {31'd0, wbEn}, '0);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", '0, '1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    ptrR2 = 32'h0000_1000; ptrR3 = 32'h0000_2002; ptrR4 = 32'h0000_3001; ptrR5 = 32'h0000_0000;
    idxR8 = 32'h0000_0010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!memValid, "R10", "memValid in reset", {31'd0, memValid}, '0);
    check(!wbEn, "R10", "wbEn in reset", {31'd0, wbEn}, '0);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(reqReady, "R10", "reqReady after reset", {31'd0, reqReady}, 32'd1);
    @(posedge clk); #1;

    // R1 base selection, every update mode and both sizes
    issue(2'd0, 2'd0, 1'b0);   // R3 keep
    issue(2'd1, 2'd1, 1'b0);   // R4 word post-inc
    issue(2'd0, 2'd1, 1'b1);   // R4 long post-inc
    issue(2'd2, 2'd2, 1'b0);   // R5 index
    issue(2'd3, 2'd3, 1'b0);   // R6 + R11 wrap from zero
    issue(2'd3, 2'd3, 1'b1);   // R6 + R11 long wrap
    issue(2'd0, 2'd3, 1'b1);   // R6 long pre-dec aligned
    issue(2'd1, 2'd0, 1'b1);   // R9 long misaligned
    issue(2'd2, 2'd0, 1'b0);   // R9 word misaligned
    idxR8 = 32'hFFFF_FFF0;
    issue(2'd1, 2'd2, 1'b1);   // R5 negative index

    // R8 stall: first access stalled, second request waits
    @(posedge clk); #1;
    memStall = 1'b1;
    issue(2'd2, 2'd1, 1'b1);
    fork
      issue(2'd1, 2'd3, 1'b0);
    join_none
    repeat (4) @(posedge clk);
    #1 memStall = 1'b0;
    repeat (2) @(posedge clk);
    #1 memStall = 1'b1;        // stall the queued access too
    repeat (3) @(posedge clk);
    #1 memStall = 1'b0;
    repeat (4) @(posedge clk);

    check(expQ.size() == 0, "R2", "all results delivered", expQ.size(), '0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule